// File: doc/BRIEF.md
# Double-Buffered Analog Output Register Front End

This block sits between a byte-wide host register bus and one or two 16-bit digital-to-analog converters. Each channel has two registers. The first is a holding register, which the host loads one byte at a time. The second is an output register, which drives the converter. Byte writes go only to the holding register, so the converter never sees a half-written code.

A separate write to a channel's strobe address copies the holding value into the output register. One shared strobe address copies both channels on the same clock edge, so a two-channel output can change as one step. Each load also raises a one-cycle update pulse for the channel that was loaded. A read at offset zero returns an identification byte, which tells software how many channels the build has. The channel count is a build parameter.

Top module: `aout_dbuf`

## Requirements
- R1: A write to a channel's low-byte address (0x0D + 8·n) or high-byte address (0x0E + 8·n) changes only that channel's holding register. The channel's output code and update pulse do not change on that write.
- R2: A write to a channel's strobe address (0x0B + 8·n) copies that channel's holding value to its output code one clock after the write. In that same cycle the channel's update pulse is high for exactly one cycle. No other channel changes.
- R3: A write to the shared strobe address 0x1B loads every built channel's output in the same cycle and raises every update pulse together.
- R4: The data byte carried by a strobe write has no effect on any output code.
- R5: A read strobe at offset 0x00 gives the ID on the read data one cycle later. The ID is 0xE2 for a one-channel build and 0xE3 for a two-channel build. Reads at any other offset return 0x00.
- R6: In a one-channel build, writes to the channel-1 addresses (0x13, 0x15, 0x16) change nothing. The shared strobe loads channel 0 only.
- R7: Synchronous reset clears all holding and output registers to 0x0000 and forces all update pulses low.
- R8: The output code is the stored 16-bit two's complement word unchanged. The low byte is bits 7:0 and the high byte is bits 15:8.
- R9: Writes to unmapped offsets change no holding register, output code or update pulse.
- R10: Strobes on consecutive cycles each produce their own update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | BYTE_W | Write data byte |
| bus_rdata | output | BYTE_W | Registered read data |
| dac_code | output | NUM_CH·2·BYTE_W | Output codes, channel n in slice n |
| dac_load | output | NUM_CH | One-cycle update pulse per channel |

## Verification
The hardest case to bring about is a holding register that differs from its output register while a strobe arrives for the other channel, or while the shared strobe arrives. In that state a wrong decode or a swapped channel shows up as a wrong code. The stimulus preloads distinct signed values into both holding registers, then strobes one channel, then both. It also sends stray writes between the strobes. A one-channel build is driven on the same bus in parallel, so each channel-1 access is checked against a design that must ignore it.

// File: rtl/aout_pkg.sv
package aout_pkg;
  localparam int unsigned STRB_BASE = 'h0B;
  localparam int unsigned LO_BASE   = 'h0D;
  localparam int unsigned HI_BASE   = 'h0E;
  localparam int unsigned CH_STRIDE = 'h08;
  localparam int unsigned BOTH_STRB = 'h1B;
  localparam int unsigned ID_OFS    = 'h00;
  localparam int unsigned ID_ONE    = 'hE2;
  localparam int unsigned ID_TWO    = 'hE3;

  function automatic int unsigned id_for(input int unsigned n);
    return (n >= 2) ? ID_TWO : ID_ONE;
  endfunction
endpackage

// File: rtl/aout_decode.sv
module aout_decode #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic [NUM_CH-1:0] strb
);
  import aout_pkg::*;

  localparam logic [ADDR_W-1:0] BOTH_A = ADDR_W'(BOTH_STRB);

  logic both_hit;
  assign both_hit = bus_wr && (bus_addr == BOTH_A);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_BASE + g * CH_STRIDE);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_BASE + g * CH_STRIDE);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STRB_BASE + g * CH_STRIDE);
    always_comb begin
      lo_we[g] = bus_wr && (bus_addr == LO_A);
      hi_we[g] = bus_wr && (bus_addr == HI_A);
      strb[g]  = (bus_wr && (bus_addr == ST_A)) || both_hit;
    end
  end
endmodule

// File: rtl/aout_chan.sv
module aout_chan #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic                strb,
  output logic [2*BYTE_W-1:0] code,
  output logic                load
);
  localparam int CODE_W = 2 * BYTE_W;

  logic [CODE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else begin
      if (lo_we) hold_q[BYTE_W-1:0]      <= wdata;
      if (hi_we) hold_q[CODE_W-1:BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      load <= 1'b0;
    end else begin
      load <= strb;
      if (strb) code <= hold_q;
    end
  end
endmodule

// File: rtl/aout_readback.sv
module aout_readback #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_rdata
);
  import aout_pkg::*;

  localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_OFS);
  localparam logic [BYTE_W-1:0] ID_VAL = BYTE_W'(id_for(NUM_CH));

  always_ff @(posedge clk) begin
    if (rst)                            bus_rdata <= '0;
    else if (bus_rd && bus_addr == ID_A) bus_rdata <= ID_VAL;
    else                                bus_rdata <= '0;
  end
endmodule

// File: rtl/aout_dbuf.sv
module aout_dbuf #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [BYTE_W-1:0]            bus_wdata,
  output logic [BYTE_W-1:0]            bus_rdata,
  output logic [NUM_CH*2*BYTE_W-1:0]   dac_code,
  output logic [NUM_CH-1:0]            dac_load
);
  localparam int CODE_W = 2 * BYTE_W;

  logic [NUM_CH-1:0] lo_we, hi_we, strb;

  aout_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .lo_we   (lo_we),
    .hi_we   (hi_we),
    .strb    (strb)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    aout_chan #(.BYTE_W(BYTE_W)) u_chan (
      .clk  (clk),
      .rst  (rst),
      .wdata(bus_wdata),
      .lo_we(lo_we[g]),
      .hi_we(hi_we[g]),
      .strb (strb[g]),
      .code (dac_code[g*CODE_W +: CODE_W]),
      .load (dac_load[g])
    );
  end

  aout_readback #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_CH(NUM_CH)) u_rdbk (
    .clk      (clk),
    .rst      (rst),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/aout_dbuf_chk.sv
module aout_dbuf_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [BYTE_W-1:0]          bus_rdata,
  input logic [NUM_CH*2*BYTE_W-1:0] dac_code,
  input logic [NUM_CH-1:0]          dac_load
);
  import aout_pkg::*;

  localparam logic [ADDR_W-1:0] BOTH_A = ADDR_W'(BOTH_STRB);
  localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_OFS);
  localparam logic [BYTE_W-1:0] ID_VAL = BYTE_W'(id_for(NUM_CH));

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !(|dac_load) |-> $stable(dac_code)); // R1

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> dac_load == '0); // R2

  AST_SHARED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == BOTH_A) |=> (&dac_load)); // R3

  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ID_A) |=> bus_rdata == ID_VAL); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (dac_load == '0 && dac_code == '0)); // R7

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STRB_BASE + g * CH_STRIDE);
    AST_CHAN_STROBE: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ST_A) |=> dac_load[g]); // R2
  end
endmodule

bind aout_dbuf aout_dbuf_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .dac_code (dac_code),
  .dac_load (dac_load)
);

// File: tb/aout_dbuf_bench.sv
module aout_dbuf_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] rdata2, rdata1;
  logic [31:0] code2;
  logic [15:0] code1;
  logic [1:0] load2;
  logic [0:0] load1;

  always #2 clk = ~clk;

  aout_dbuf #(.NUM_CH(2)) u_aout_dbuf (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .dac_code(code2), .dac_load(load2));

  aout_dbuf #(.NUM_CH(1)) u_aout_dbuf_one (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .dac_code(code1), .dac_load(load1));

  typedef struct packed {
    logic [1:0]  m;
    logic [15:0] c0;
    logic [15:0] c1;
  } ev_t;

  ev_t q2[$];
  ev_t q1[$];
  logic [15:0] hold2 [2];
  logic [15:0] out2  [2];
  logic [15:0] hold1, out1;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    hold2[0] = 0; hold2[1] = 0; out2[0] = 0; out2[1] = 0; hold1 = 0; out1 = 0;
  endtask

  // Driver: called at a negedge, returns at the next negedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [1:0] m2;
    logic m1;
    ev_t e;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    m2 = 2'b00; m1 = 1'b0;
    for (int n = 0; n < 2; n++) begin
      if (a == 8'h0D + 8*n) hold2[n][7:0]  = d;
      if (a == 8'h0E + 8*n) hold2[n][15:8] = d;
      if (a == 8'h0B + 8*n || a == 8'h1B) m2[n] = 1'b1;
    end
    if (a == 8'h0D) hold1[7:0]  = d;
    if (a == 8'h0E) hold1[15:8] = d;
    if (a == 8'h0B || a == 8'h1B) m1 = 1'b1;
    if (m2 != 0) begin
      for (int n = 0; n < 2; n++) if (m2[n]) out2[n] = hold2[n];
      e.m = m2; e.c0 = out2[0]; e.c1 = out2[1];
      q2.push_back(e);
    end
    if (m1) begin
      out1 = hold1;
      e.m = 2'b01; e.c0 = out1; e.c1 = 16'h0;
      q1.push_back(e);
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr16(input int ch, input logic [15:0] v);
    wr(8'h0D + 8*ch, v[7:0]);
    wr(8'h0E + 8*ch, v[15:8]);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e2, input logic [7:0] e1);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(rdata2 == e2, "R5 read two-channel", {24'h0, rdata2}, {24'h0, e2});
    chk(rdata1 == e1, "R5 read one-channel", {24'h0, rdata1}, {24'h0, e1});
  endtask

  task automatic chk_outs(input string req);
    chk(code2 == {out2[1], out2[0]}, req, code2, {out2[1], out2[0]});
    chk(code1 == out1, req, {16'h0, code1}, {16'h0, out1});
    chk(load2 == 2'b00 && load1 == 1'b0, req, {30'h0, load2}, 32'h0);
  endtask

  // Monitor / scoreboard
  initial begin
    ev_t e;
    forever begin
      @(negedge clk);
      if (!rst && !done) begin
        if (load2 != 2'b00) begin
          if (q2.size() == 0) chk(1'b0, "R2 unexpected pulse two-channel", {30'h0, load2}, 32'h0);
          else begin
            e = q2.pop_front();
            chk(load2 == e.m, "R2 R3 R10 pulse mask", {30'h0, load2}, {30'h0, e.m});
            chk(code2 == {e.c1, e.c0}, "R2 R3 R8 loaded codes", code2, {e.c1, e.c0});
          end
        end
        if (load1 != 1'b0) begin
          if (q1.size() == 0) chk(1'b0, "R6 unexpected pulse one-channel", {31'h0, load1}, 32'h0);
          else begin
            e = q1.pop_front();
            chk(code1 == e.c0, "R6 one-channel loaded code", {16'h0, code1}, {16'h0, e.c0});
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    chk(code2 == 32'h0 && code1 == 16'h0, "R7 reset codes", code2, 32'h0);
    chk(load2 == 2'b00 && load1 == 1'b0, "R7 reset pulses", {30'h0, load2}, 32'h0);

    // R1: byte writes leave output alone
    wr16(0, 16'h1234);
    chk_outs("R1 output held after byte writes");
    // R2 R4: strobe with junk data
    wr(8'h0B, 8'hA5);
    @(negedge clk);
    chk_outs("R2 R4 after channel-0 strobe");

    // R6 R8: negative code on channel 1
    wr16(1, 16'h8001);
    chk_outs("R1 R6 channel-1 bytes");
    wr(8'h13, 8'h5A);
    @(negedge clk);
    chk_outs("R2 R6 after channel-1 strobe");

    // R3: shared strobe with distinct pending values
    wr16(0, 16'hFFFF);
    wr16(1, 16'h7FFF);
    chk_outs("R1 holding preloaded");
    wr(8'h1B, 8'hFF);
    @(negedge clk);
    chk_outs("R3 after shared strobe");

    // R9: stray writes
    wr(8'h0C, 8'h11);
    wr(8'h0F, 8'h22);
    wr(8'h1C, 8'h33);
    wr(8'h00, 8'h44);
    @(negedge clk);
    chk_outs("R9 stray writes");
    wr(8'h1B, 8'h00);
    @(negedge clk);
    chk_outs("R9 holding unchanged by stray writes");

    // R10: back-to-back strobes with change between
    wr(8'h0D, 8'h01);
    wr(8'h0B, 8'h00);
    wr(8'h0B, 8'h00);
    wr(8'h15, 8'hC3);
    wr(8'h13, 8'h00);
    wr(8'h1B, 8'h00);
    @(negedge clk);
    chk_outs("R10 consecutive strobes");

    // R5 reads
    rd(8'h00, 8'hE3, 8'hE2);
    rd(8'h0D, 8'h00, 8'h00);

    // R7 mid-run reset
    wr16(0, 16'hBEEF);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    q2.delete(); q1.delete();
    chk(code2 == 32'h0 && code1 == 16'h0, "R7 mid-run reset codes", code2, 32'h0);
    wr(8'h1B, 8'h77);
    @(negedge clk);
    chk_outs("R7 holding cleared by reset");

    chk(q2.size() == 0 && q1.size() == 0, "R2 all expected pulses seen",
        q2.size() + q1.size(), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule